// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits behind the receive framer of an Ethernet port and decides, for every incoming frame, whether the destination address is wanted and which of eight receive channels takes the frame. The framer presents the 48-bit destination address together with a one-cycle strobe. One clock later the filter returns a registered verdict: an accept flag, a 3-bit channel number and a 3-bit code that says which rule matched.

A small write-only configuration port loads the filter state. Three rules handle group traffic. The promiscuous, broadcast and multicast classes can each be switched on separately, and each has its own programmed channel. Multicast frames are admitted through a 64-entry hash table indexed by a 6-bit XOR fold of the address. Unicast frames are compared against a station address. The last byte of that address is held per channel, and each channel's unicast acceptance is gated by its own enable bit.

The address bus carries the first byte received in bits 7:0 and the sixth byte in bits 47:40, so the group bit is bit 0.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle in which `da_valid` is high, and low otherwise. Every strobed address produces one verdict, including strobes on consecutive cycles.
- R2: When the promiscuous enable (class word bit 21) is set, every frame is accepted. The channel is class word bits 18:16 and the match code is 4.
- R3: An all-ones destination is broadcast. If the promiscuous enable is clear, a broadcast frame is accepted with match code 3 on the channel in class word bits 10:8 when the broadcast enable (bit 13) is set. It is rejected when that enable is clear, and it is never treated as multicast.
- R4: A destination with bit 0 set that is not broadcast is multicast. It is accepted with match code 2 on the channel in class word bits 2:0 only when the multicast enable (bit 5) is set and the hash table bit it selects is one.
- R5: The hash bit i is the XOR of address bits i, i+6, i+12, …, i+42. Hash values 0 to 31 select that bit of the low table word (offset 3). Values 32 to 63 select bit (hash − 32) of the high table word (offset 4).
- R6: With both table words at all ones and the multicast enable set, every multicast frame is accepted.
- R7: A destination with bit 0 clear is unicast. It matches channel c when the enable bit c of the unicast mask is set, address bits 31:0 equal the offset-5 register, bits 39:32 equal the offset-6 register's bits 7:0, and bits 47:40 equal the offset-(8+c) register's bits 7:0. The lowest matching channel wins, with match code 1.
- R8: A write to offset 1 sets the unicast mask bits that are one in the data. A write to offset 2 clears the mask bits that are one in the data. Other mask bits keep their value.
- R9: The rules are tried in a fixed order: promiscuous first, then broadcast, then multicast, then unicast.
- R10: A frame that matches no rule gives accept 0, channel 0 and match code 0.
- R11: Reset clears all configuration, so every frame is rejected. While `res_valid` is low, `res_accept`, `res_chan` and `res_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first byte in bits 7:0 |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_chan | output | 3 | Receive channel of the accepted frame |
| res_kind | output | 3 | Match code: 0 reject, 1 unicast, 2 multicast, 3 broadcast, 4 promiscuous |

## Verification
Every verdict is due on the rising edge that follows the cycle in which the address was strobed. A configuration write takes effect on the edge of its write cycle, so it applies to strobes presented from the next cycle on. The bench changes inputs on falling edges. It queues the expected verdict for each strobe at the moment it drives that strobe, and the monitor pops and compares one entry on each falling edge where `res_valid` is high. Any verdict arriving a cycle early, late, or without a matching strobe therefore shows up as a mismatch or an unexpected result.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   typedef enum logic [2:0] {
      KIND_REJECT  = 3'd0,
      KIND_UCAST   = 3'd1,
      KIND_MCAST   = 3'd2,
      KIND_BCAST   = 3'd3,
      KIND_PROMISC = 3'd4
   } match_kind_e;

   // configuration register offsets
   localparam int REG_CLASS        = 0;
   localparam int REG_UC_SET       = 1;
   localparam int REG_UC_CLR       = 2;
   localparam int REG_HASH_LO      = 3;
   localparam int REG_HASH_HI      = 4;
   localparam int REG_STA_HI       = 5;
   localparam int REG_STA_MID      = 6;
   localparam int REG_STA_LOW_BASE = 8;

   // class word field positions
   localparam int PROM_EN_BIT  = 21;
   localparam int PROM_CH_LSB  = 16;
   localparam int BCAST_EN_BIT = 13;
   localparam int BCAST_CH_LSB = 8;
   localparam int MCAST_EN_BIT = 5;
   localparam int MCAST_CH_LSB = 0;

   typedef struct packed {
      logic       prom_en;
      logic [2:0] prom_ch;
      logic       bc_en;
      logic [2:0] bc_ch;
      logic       mc_en;
      logic [2:0] mc_ch;
   } class_cfg_t;

endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
   import rxaf_pkg::*;
#(
   parameter int NUM_CHAN = 8,
   parameter int CFG_AW   = 4,
   parameter int DATA_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [CFG_AW-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   output class_cfg_t                 cls,
   output logic [NUM_CHAN-1:0]        uc_mask,
   output logic [2*DATA_W-1:0]        hash_tbl,
   output logic [DATA_W-1:0]          sta_hi,
   output logic [7:0]                 sta_mid,
   output logic [NUM_CHAN-1:0][7:0]   sta_low
);

   logic [DATA_W-1:0] hash_lo_q, hash_hi_q;

   function automatic logic hit(input int off);
      return cfg_we && (cfg_addr == CFG_AW'(off));
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls       <= '0;
         uc_mask   <= '0;
         hash_lo_q <= '0;
         hash_hi_q <= '0;
         sta_hi    <= '0;
         sta_mid   <= '0;
      end else begin
         if (hit(REG_CLASS)) begin
            cls.prom_en <= cfg_wdata[PROM_EN_BIT];
            cls.prom_ch <= cfg_wdata[PROM_CH_LSB +: 3];
            cls.bc_en   <= cfg_wdata[BCAST_EN_BIT];
            cls.bc_ch   <= cfg_wdata[BCAST_CH_LSB +: 3];
            cls.mc_en   <= cfg_wdata[MCAST_EN_BIT];
            cls.mc_ch   <= cfg_wdata[MCAST_CH_LSB +: 3];
         end
         if (hit(REG_UC_SET))
            uc_mask <= uc_mask | cfg_wdata[NUM_CHAN-1:0];
         else if (hit(REG_UC_CLR))
            uc_mask <= uc_mask & ~cfg_wdata[NUM_CHAN-1:0];
         if (hit(REG_HASH_LO)) hash_lo_q <= cfg_wdata;
         if (hit(REG_HASH_HI)) hash_hi_q <= cfg_wdata;
         if (hit(REG_STA_HI))  sta_hi    <= cfg_wdata;
         if (hit(REG_STA_MID)) sta_mid   <= cfg_wdata[7:0];
      end
   end

   // one low-byte register per channel
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_low
      always_ff @(posedge clk) begin
         if (!rst_n)
            sta_low[c] <= '0;
         else if (hit(REG_STA_LOW_BASE + c))
            sta_low[c] <= cfg_wdata[7:0];
      end
   end

   assign hash_tbl = {hash_hi_q, hash_lo_q};

endmodule

// File: rtl/rxaf_hash_fold.sv
module rxaf_hash_fold #(
   parameter int ADDR_BITS = 48,
   parameter int HASH_BITS = 6
) (
   input  logic [ADDR_BITS-1:0] addr,
   output logic [HASH_BITS-1:0] hash
);

   localparam int FOLDS = (ADDR_BITS + HASH_BITS - 1) / HASH_BITS;

   for (genvar i = 0; i < HASH_BITS; i++) begin : g_bit
      logic [FOLDS-1:0] taps;
      for (genvar k = 0; k < FOLDS; k++) begin : g_tap
         if (i + k*HASH_BITS < ADDR_BITS) begin : g_in
            assign taps[k] = addr[i + k*HASH_BITS];
         end else begin : g_pad
            assign taps[k] = 1'b0;
         end
      end
      assign hash[i] = ^taps;
   end

endmodule

// File: rtl/rxaf_ucast_match.sv
module rxaf_ucast_match #(
   parameter int NUM_CHAN = 8,
   parameter int DATA_W   = 32,
   localparam int CH_W    = $clog2(NUM_CHAN)
) (
   input  logic [47:0]               addr,
   input  logic [NUM_CHAN-1:0]       uc_mask,
   input  logic [DATA_W-1:0]         sta_hi,
   input  logic [7:0]                sta_mid,
   input  logic [NUM_CHAN-1:0][7:0]  sta_low,
   output logic                      uc_hit,
   output logic [CH_W-1:0]           uc_ch
);

   logic                upper_eq;
   logic [NUM_CHAN-1:0] chan_hit;

   // bytes 0..4 are shared by every channel
   assign upper_eq = !addr[0] && (addr[39:0] == {sta_mid, sta_hi});

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      assign chan_hit[c] = uc_mask[c] && upper_eq && (addr[47:40] == sta_low[c]);
   end

   always_comb begin
      uc_hit = |chan_hit;
      uc_ch  = '0;
      for (int c = NUM_CHAN-1; c >= 0; c--)
         if (chan_hit[c]) uc_ch = CH_W'(c);
   end

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
   import rxaf_pkg::*;
#(
   parameter int HASH_BITS = 6,
   parameter int CH_W      = 3,
   localparam int TBL_W    = 2**HASH_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 da_valid,
   input  logic [47:0]          da,
   input  class_cfg_t           cls,
   input  logic [TBL_W-1:0]     hash_tbl,
   input  logic [HASH_BITS-1:0] hash,
   input  logic                 uc_hit,
   input  logic [CH_W-1:0]      uc_ch,
   output logic                 res_valid,
   output logic                 res_accept,
   output logic [2:0]           res_chan,
   output match_kind_e          res_kind
);

   logic        all_ones, nxt_acc;
   logic [2:0]  nxt_ch;
   match_kind_e nxt_kind;

   assign all_ones = &da;

   always_comb begin
      nxt_acc  = 1'b0;
      nxt_ch   = '0;
      nxt_kind = KIND_REJECT;
      if (cls.prom_en) begin
         nxt_acc  = 1'b1;
         nxt_ch   = cls.prom_ch;
         nxt_kind = KIND_PROMISC;
      end else if (all_ones) begin
         if (cls.bc_en) begin
            nxt_acc  = 1'b1;
            nxt_ch   = cls.bc_ch;
            nxt_kind = KIND_BCAST;
         end
      end else if (da[0]) begin
         if (cls.mc_en && hash_tbl[hash]) begin
            nxt_acc  = 1'b1;
            nxt_ch   = cls.mc_ch;
            nxt_kind = KIND_MCAST;
         end
      end else if (uc_hit) begin
         nxt_acc  = 1'b1;
         nxt_ch   = 3'(uc_ch);
         nxt_kind = KIND_UCAST;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_chan   <= '0;
         res_kind   <= KIND_REJECT;
      end else begin
         res_valid  <= da_valid;
         res_accept <= da_valid && nxt_acc;
         res_chan   <= da_valid ? nxt_ch : 3'd0;
         res_kind   <= da_valid ? nxt_kind : KIND_REJECT;
      end
   end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int NUM_CHAN  = 8,
   parameter int HASH_BITS = 6,
   parameter int CFG_AW    = 4,
   parameter int DATA_W    = 32,
   parameter int ADDR_BITS = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   input  logic                 da_valid,
   input  logic [ADDR_BITS-1:0] da,
   output logic                 res_valid,
   output logic                 res_accept,
   output logic [2:0]           res_chan,
   output logic [2:0]           res_kind
);

   localparam int CH_W  = $clog2(NUM_CHAN);
   localparam int TBL_W = 2**HASH_BITS;

   if (NUM_CHAN < 2 || NUM_CHAN > 8) begin : g_bad_chan
      $error("NUM_CHAN must be 2..8 to fit the 3-bit channel fields");
   end
   if (ADDR_BITS != 48 || DATA_W != 32) begin : g_bad_width
      $error("station layout needs a 48-bit address and 32-bit registers");
   end
   if (TBL_W != 2*DATA_W) begin : g_bad_hash
      $error("hash table must span exactly two register words");
   end
   if (REG_STA_LOW_BASE + NUM_CHAN > 2**CFG_AW) begin : g_bad_aw
      $error("CFG_AW too small for per-channel station registers");
   end

   class_cfg_t                cfg_class;
   logic [NUM_CHAN-1:0]       uc_mask;
   logic [TBL_W-1:0]          hash_tbl;
   logic [DATA_W-1:0]         sta_hi;
   logic [7:0]                sta_mid;
   logic [NUM_CHAN-1:0][7:0]  sta_low;
   logic [HASH_BITS-1:0]      hash;
   logic                      uc_hit;
   logic [CH_W-1:0]           uc_ch;
   match_kind_e               kind_q;

   rxaf_cfg_regs #(.NUM_CHAN(NUM_CHAN), .CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cls(cfg_class), .uc_mask(uc_mask),
      .hash_tbl(hash_tbl), .sta_hi(sta_hi), .sta_mid(sta_mid), .sta_low(sta_low)
   );

   rxaf_hash_fold #(.ADDR_BITS(ADDR_BITS), .HASH_BITS(HASH_BITS)) u_hash (
      .addr(da), .hash(hash)
   );

   rxaf_ucast_match #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_uc (
      .addr(da), .uc_mask(uc_mask), .sta_hi(sta_hi), .sta_mid(sta_mid),
      .sta_low(sta_low), .uc_hit(uc_hit), .uc_ch(uc_ch)
   );

   rxaf_decide #(.HASH_BITS(HASH_BITS), .CH_W(CH_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da), .cls(cfg_class),
      .hash_tbl(hash_tbl), .hash(hash), .uc_hit(uc_hit), .uc_ch(uc_ch),
      .res_valid(res_valid), .res_accept(res_accept), .res_chan(res_chan),
      .res_kind(kind_q)
   );

   assign res_kind = kind_q;

endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk
   import rxaf_pkg::*;
#(
   parameter int NUM_CHAN = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                da_valid,
   input logic [47:0]         da,
   input class_cfg_t          cfg_class,
   input logic [NUM_CHAN-1:0] uc_mask,
   input logic                res_valid,
   input logic                res_accept,
   input logic [2:0]          res_chan,
   input logic [2:0]          res_kind
);

   // R1
   strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid);

   // R1
   no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !res_valid);

   // R2
   promisc_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && cfg_class.prom_en) |=>
      (res_accept && res_kind == 3'd4 && res_chan == $past(cfg_class.prom_ch)));

   // R3
   bcast_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && (&da) && !cfg_class.prom_en && cfg_class.bc_en) |=>
      (res_accept && res_kind == 3'd3 && res_chan == $past(cfg_class.bc_ch)));

   // R4
   mcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da[0] && !cfg_class.prom_en && !cfg_class.mc_en) |=>
      (res_kind != 3'd2));

   // R4
   mcast_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == 3'd2) |-> (res_chan == $past(cfg_class.mc_ch)));

   // R8
   ucast_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == 3'd1) |-> ((($past(uc_mask)) >> res_chan) & 1) != 0);

   // R10
   reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_accept) |-> (res_kind == 3'd0 && res_chan == 3'd0));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_accept && res_kind == 3'd0 && res_chan == 3'd0));

endmodule

bind eth_rx_addr_filter rxaf_chk #(.NUM_CHAN(NUM_CHAN)) chk_i (
   .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
   .cfg_class(cfg_class), .uc_mask(uc_mask), .res_valid(res_valid),
   .res_accept(res_accept), .res_chan(res_chan), .res_kind(res_kind)
);

// File: tb/eth_rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module eth_rx_addr_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        res_valid, res_accept;
   logic [2:0]  res_chan, res_kind;

   always #4 clk = ~clk;

   eth_rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
      .res_valid(res_valid), .res_accept(res_accept),
      .res_chan(res_chan), .res_kind(res_kind)
   );

   typedef struct {
      logic       acc;
      logic [2:0] ch;
      logic [2:0] kind;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0;
   int   bad = 0;

   // bench copy of the programmed state
   logic [31:0] m_class = '0, m_hlo = '0, m_hhi = '0, m_shi = '0;
   logic [7:0]  m_mask = '0, m_smid = '0;
   logic [7:0]  m_slow [8];

   localparam logic [47:0] ONES = {48{1'b1}};

   function automatic logic [5:0] fold6(input logic [47:0] a);
      logic [5:0] h = '0;
      for (int j = 0; j < 48; j++) h[j % 6] ^= a[j];
      return h;
   endfunction

   function automatic exp_t predict(input logic [47:0] a, input string tag);
      exp_t e;
      logic [5:0] h;
      e.acc = 1'b0; e.ch = 3'd0; e.kind = 3'd0; e.tag = tag;
      h = fold6(a);
      if (m_class[21]) begin
         e.acc = 1'b1; e.ch = m_class[18:16]; e.kind = 3'd4;
      end else if (a == ONES) begin
         if (m_class[13]) begin e.acc = 1'b1; e.ch = m_class[10:8]; e.kind = 3'd3; end
      end else if (a[0]) begin
         if (m_class[5] && ((h < 6'd32) ? m_hlo[h[4:0]] : m_hhi[h[4:0]])) begin
            e.acc = 1'b1; e.ch = m_class[2:0]; e.kind = 3'd2;
         end
      end else begin
         for (int c = 7; c >= 0; c--)
            if (m_mask[c] && a[31:0] == m_shi && a[39:32] == m_smid && a[47:40] == m_slow[c]) begin
               e.acc = 1'b1; e.ch = 3'(c); e.kind = 3'd1;
            end
      end
      return e;
   endfunction

   task automatic cfg_wr(input int off, input logic [31:0] d);
      @(negedge clk);
      da_valid  = 1'b0;
      cfg_we    = 1'b1;
      cfg_addr  = 4'(off);
      cfg_wdata = d;
      case (off)
         0: m_class = d;
         1: m_mask  = m_mask | d[7:0];
         2: m_mask  = m_mask & ~d[7:0];
         3: m_hlo   = d;
         4: m_hhi   = d;
         5: m_shi   = d;
         6: m_smid  = d[7:0];
         default: if (off >= 8) m_slow[off-8] = d[7:0];
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [47:0] a, input string tag);
      @(negedge clk);
      cfg_we   = 1'b0;
      da       = a;
      da_valid = 1'b1;
      sb.push_back(predict(a, tag));
   endtask

   task automatic quiet();
      @(negedge clk);
      da_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         exp_t e;
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R1 unexpected result: acc/ch/kind=%0d/%0d/%0d expected none",
                     res_accept, res_chan, res_kind);
         end else begin
            e = sb.pop_front();
            if (res_accept !== e.acc || res_chan !== e.ch || res_kind !== e.kind) begin
               bad++;
               $display("FAIL %s: acc/ch/kind=%0d/%0d/%0d expected %0d/%0d/%0d",
                        e.tag, res_accept, res_chan, res_kind, e.acc, e.ch, e.kind);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(8 * 20000);
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      finish_run();
   end

   initial begin
      logic [47:0] st_base;
      for (int c = 0; c < 8; c++) m_slow[c] = '0;
      st_base = {8'h00, 8'h66, 32'h4433_2210};

      repeat (3) @(negedge clk);
      total++;
      if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_chan !== 3'd0 || res_kind !== 3'd0) begin
         bad++;
         $display("FAIL R11 reset outputs: v/acc/ch/kind=%0d/%0d/%0d/%0d expected 0/0/0/0",
                  res_valid, res_accept, res_chan, res_kind);
      end
      rst_n = 1'b1;

      // R11: default config rejects everything
      send(ONES, "R11 bcast after reset");
      send(48'h1, "R11 mcast after reset");
      send(48'h0, "R11 ucast after reset");
      quiet();

      // R7: station address and per-channel low bytes
      cfg_wr(5, 32'h4433_2210);
      cfg_wr(6, 32'h0000_0066);
      cfg_wr(8+3, 32'h55);
      cfg_wr(8+5, 32'h55);
      cfg_wr(8+6, 32'h77);
      cfg_wr(1, 32'h68);
      send({8'h55, st_base[39:0]}, "R7 lowest of ch3/ch5");
      send({8'h77, st_base[39:0]}, "R7 ch6");
      send({8'h88, st_base[39:0]}, "R10 low byte miss");
      send({8'h55, 8'h67, st_base[31:0]}, "R10 mid byte miss");
      quiet();

      // R8: clear then set
      cfg_wr(2, 32'h08);
      send({8'h55, st_base[39:0]}, "R8 ch3 cleared goes ch5");
      quiet();
      cfg_wr(1, 32'h01);
      send({8'h55, st_base[39:0]}, "R8 set keeps ch5");
      send({8'h00, st_base[39:0]}, "R8 ch0 enabled");
      quiet();

      // R4/R5: multicast through the hash table
      cfg_wr(0, 32'h0000_0022);
      cfg_wr(3, 32'h0000_0002);
      send(48'h1, "R5 hash 1 low word hit");
      send(48'h21, "R5 hash 33 miss");
      send(48'h3, "R4 hash 3 miss");
      send({8'h55, st_base[39:0]}, "R7 ucast with mcast on");
      quiet();
      cfg_wr(3, 32'h0);
      cfg_wr(4, 32'h0000_0002);
      send(48'h1, "R5 hash 1 low word empty");
      send(48'h21, "R5 hash 33 high word hit");
      quiet();
      cfg_wr(0, 32'h0);
      send(48'h21, "R4 mcast disabled");
      quiet();

      // R6: all-ones table
      cfg_wr(0, 32'h0000_0022);
      cfg_wr(3, 32'hFFFF_FFFF);
      cfg_wr(4, 32'hFFFF_FFFF);
      send(48'h0123_4567_89AB, "R6 any mcast a");
      send(48'hFEDC_BA98_7655, "R6 any mcast b");
      send(48'hA5A5_A5A5_A5A5, "R6 any mcast c");
      send(ONES, "R3 bcast disabled not mcast");
      quiet();

      // R3/R9: broadcast over multicast
      cfg_wr(0, 32'h0000_2722);
      send(ONES, "R3 R9 bcast to ch7");
      quiet();

      // R1: back-to-back strobes
      send(48'h1, "R1 b2b mcast");
      send(ONES, "R1 b2b bcast");
      send({8'h55, st_base[39:0]}, "R1 b2b ucast");
      send({8'h88, st_base[39:0]}, "R1 b2b reject");
      send(48'h3, "R1 b2b mcast 2");
      quiet();

      // R2/R9: promiscuous wins over all
      cfg_wr(0, 32'h0024_2722);
      send(ONES, "R2 R9 promisc bcast");
      send({8'h55, st_base[39:0]}, "R2 R9 promisc ucast");
      send(48'h1, "R2 promisc mcast");
      send({8'h88, st_base[39:0]}, "R2 promisc nonmatch");
      quiet();
      cfg_wr(0, 32'h0020_0000);
      send({8'h88, st_base[39:0]}, "R2 promisc ch0");
      quiet();

      repeat (4) @(negedge clk);
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R1 missing results: actual=%0d pending expected=0", sb.size());
      end
      finish_run();
   end

endmodule